// File: doc/BRIEF.md
# PWM Shadow Register Update Controller

This block keeps double-buffered copies of the four configuration words of one PWM generator: the period (load) value, the two compare thresholds A and B, and the action word that tells the waveform logic how to react to counter events. Software writes land in a shadow copy. Each word then moves into the active copy that the generator reads, at a moment picked by that word's own update policy. The policy can be right away, at the next counter zero, or at the next counter zero after a global sync request.

The policies come from an 8-bit mode word. Software writes it through the same register write port as the shadowed words. A global sync request is a one-cycle pulse. The controller latches it, reports it on `sync_pending`, and clears it when the counter next reaches zero. That zero also lets every globally synchronized word that has a waiting write move into its active copy. The PWM counter supplies a one-cycle counter-zero strobe and is not part of this block.

Top module: `pwm_shadow_ctrl`

## Requirements
- R1: After reset all four active words read 0, `sync_pending` is 0, and the mode word is 0. With a zero mode word the action word is immediate and the other three words are updated at the next counter zero.
- R2: Mode word layout. Bits 7:6 select the action-word policy. Bit 5 selects the compare-B policy, bit 4 the compare-A policy and bit 3 the load policy. For a 1-bit field, 0 means next-zero and 1 means global. Bits 2:0 are ignored.
- R3: With action policy 0, a write to the action word (`wr_sel`=3) shows on `action_act` on the clock edge that accepts the write.
- R4: Action policy 1 behaves exactly like policy 0 (immediate).
- R5: Under the next-zero policy (action policy 2, or a 1-bit field of 0), a written value stays out of the active word until a clock edge where `cnt_zero` is high. It is applied on that edge.
- R6: Under the global policy (action policy 3, or a 1-bit field of 1), a counter zero with no pending request leaves the active word unchanged. The value is applied at the first counter zero that finds a request pending.
- R7: `sync_pending` goes high on the edge after a `sync_req` pulse. It stays high until an edge where `cnt_zero` is high, and it is clear after that edge. A request that arrives together with a counter zero stays pending for the following zero.
- R8: A write that arrives in the same cycle as `cnt_zero` does not move to the active word on that edge. It waits for the next counter zero.
- R9: A word moves to its active copy only once per write. Later counter zeros leave it unchanged. Several writes before a transfer keep only the last value.
- R10: Write select codes: 0 load, 1 compare A, 2 compare B, 3 action, 4 mode word. Codes 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (0 load, 1 cmp A, 2 cmp B, 3 action, 4 mode) |
| wr_data | input | DATA_W | Write data; the mode word uses bits 7:0 |
| sync_req | input | 1 | One-cycle global sync request |
| cnt_zero | input | 1 | One-cycle strobe when the PWM counter is zero |
| load_act | output | DATA_W | Active load value |
| cmpa_act | output | DATA_W | Active compare A value |
| cmpb_act | output | DATA_W | Active compare B value |
| action_act | output | DATA_W | Active action word |
| sync_pending | output | 1 | Global sync request latched and not yet consumed |

## Verification
The hardest case to reach is a globally synchronized word with a waiting write while the request timing varies around the counter zero. This includes a zero with no request, a request in the same cycle as a zero, and a write in the same cycle as the zero that consumes the request. Directed sequences set up each of these orders explicitly. A long random phase then draws writes, mode changes, requests and zero strobes at different densities, so that these overlaps come up many times. A bench reference model computes every expected output each cycle.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;

    localparam int NUM_SLOTS = 4;
    localparam int SEL_W     = 3;
    localparam int MODE_W    = 8;

    localparam logic [SEL_W-1:0] SEL_LOAD   = 3'd0;
    localparam logic [SEL_W-1:0] SEL_CMPA   = 3'd1;
    localparam logic [SEL_W-1:0] SEL_CMPB   = 3'd2;
    localparam logic [SEL_W-1:0] SEL_ACTION = 3'd3;
    localparam logic [SEL_W-1:0] SEL_MODE   = 3'd4;

    typedef enum logic [1:0] {
        UPD_IMM    = 2'd0,
        UPD_LOCAL  = 2'd1,
        UPD_GLOBAL = 2'd2
    } upd_mode_e;

    typedef struct packed {
        logic [1:0] action_pol;
        logic       cmpb_glob;
        logic       cmpa_glob;
        logic       load_glob;
    } mode_fields_t;

    function automatic mode_fields_t unpack_mode(input logic [MODE_W-1:0] w);
        mode_fields_t f;
        f.action_pol = w[7:6];
        f.cmpb_glob  = w[5];
        f.cmpa_glob  = w[4];
        f.load_glob  = w[3];
        return f;
    endfunction

    function automatic upd_mode_e one_bit_mode(input logic glob);
        return glob ? UPD_GLOBAL : UPD_LOCAL;
    endfunction

    function automatic upd_mode_e action_mode(input logic [1:0] pol);
        upd_mode_e m;
        case (pol)
            2'd2:    m = UPD_LOCAL;
            2'd3:    m = UPD_GLOBAL;
            default: m = UPD_IMM;
        endcase
        return m;
    endfunction

    function automatic upd_mode_e slot_mode(input mode_fields_t f, input int idx);
        upd_mode_e m;
        case (idx)
            0:       m = one_bit_mode(f.load_glob);
            1:       m = one_bit_mode(f.cmpa_glob);
            2:       m = one_bit_mode(f.cmpb_glob);
            default: m = action_mode(f.action_pol);
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pwm_mode_reg.sv
module pwm_mode_reg
    import pwm_shadow_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  logic [MODE_W-1:0] wr_word,
    output logic [MODE_W-1:0] mode_word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_word <= '0;
        end else if (wr_hit) begin
            mode_word <= wr_word;
        end
    end
endmodule

// File: rtl/pwm_sync_tracker.sv
module pwm_sync_tracker (
    input  logic clk,
    input  logic rst,
    input  logic sync_req,
    input  logic cnt_zero,
    output logic pending
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
        end else begin
            pending <= sync_req | (pending & ~cnt_zero);
        end
    end
endmodule

// File: rtl/pwm_shadow_slot.sv
module pwm_shadow_slot
    import pwm_shadow_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wr_data,
    input  upd_mode_e         mode,
    input  logic              cnt_zero,
    input  logic              sync_pend,
    output logic [DATA_W-1:0] active_o
);
    logic [DATA_W-1:0] shadow_q;
    logic              dirty_q;
    logic              gate_ok;
    logic              xfer;

    assign gate_ok = (mode != UPD_GLOBAL) | sync_pend;
    assign xfer    = cnt_zero & dirty_q & gate_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            active_o <= '0;
            dirty_q  <= 1'b0;
        end else if (wr_hit) begin
            shadow_q <= wr_data;
            if (mode == UPD_IMM) begin
                active_o <= wr_data;
                dirty_q  <= 1'b0;
            end else begin
                dirty_q  <= 1'b1;
            end
        end else if (xfer) begin
            active_o <= shadow_q;
            dirty_q  <= 1'b0;
        end
    end
endmodule

// File: rtl/pwm_shadow_ctrl.sv
module pwm_shadow_ctrl
    import pwm_shadow_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sync_req,
    input  logic              cnt_zero,
    output logic [DATA_W-1:0] load_act,
    output logic [DATA_W-1:0] cmpa_act,
    output logic [DATA_W-1:0] cmpb_act,
    output logic [DATA_W-1:0] action_act,
    output logic              sync_pending
);
    logic [MODE_W-1:0] mode_q;
    mode_fields_t      fields;
    logic [DATA_W-1:0] act_q [NUM_SLOTS];

    assign fields = unpack_mode(mode_q);

    pwm_mode_reg u_mode (
        .clk       (clk),
        .rst       (rst),
        .wr_hit    (wr_en && (wr_sel == SEL_MODE)),
        .wr_word   (wr_data[MODE_W-1:0]),
        .mode_word (mode_q)
    );

    pwm_sync_tracker u_sync (
        .clk      (clk),
        .rst      (rst),
        .sync_req (sync_req),
        .cnt_zero (cnt_zero),
        .pending  (sync_pending)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(g);
        upd_mode_e slot_pol;
        assign slot_pol = slot_mode(fields, g);

        pwm_shadow_slot #(.DATA_W(DATA_W)) u_slot (
            .clk       (clk),
            .rst       (rst),
            .wr_hit    (wr_en && (wr_sel == MY_SEL)),
            .wr_data   (wr_data),
            .mode      (slot_pol),
            .cnt_zero  (cnt_zero),
            .sync_pend (sync_pending),
            .active_o  (act_q[g])
        );
    end

    assign load_act   = act_q[0];
    assign cmpa_act   = act_q[1];
    assign cmpb_act   = act_q[2];
    assign action_act = act_q[3];
endmodule

// File: rtl/pwm_shadow_chk.sv
module pwm_shadow_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [2:0]        wr_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic              sync_req,
    input logic              cnt_zero,
    input logic [7:0]        mode_q,
    input logic [DATA_W-1:0] load_act,
    input logic [DATA_W-1:0] action_act,
    input logic              sync_pending
);
    assert_pend_set_R7: assert property (@(posedge clk) disable iff (rst)
        sync_req |=> sync_pending);

    assert_pend_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (sync_pending && cnt_zero && !sync_req) |=> !sync_pending);

    assert_pend_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (!sync_pending && !sync_req) |=> !sync_pending);

    assert_load_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !cnt_zero |=> $stable(load_act));

    assert_same_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 3'd0 && cnt_zero) |=> $stable(load_act));

    assert_action_imm_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 3'd3 && !mode_q[7]) |=> (action_act == $past(wr_data)));
endmodule

bind pwm_shadow_ctrl pwm_shadow_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .wr_data      (wr_data),
    .sync_req     (sync_req),
    .cnt_zero     (cnt_zero),
    .mode_q       (mode_q),
    .load_act     (load_act),
    .action_act   (action_act),
    .sync_pending (sync_pending)
);

// File: tb/sim_pwm_shadow_ctrl.sv
module sim_pwm_shadow_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_sel = '0;
    logic [DW-1:0] wr_data = '0;
    logic          sync_req = 1'b0;
    logic          cnt_zero = 1'b0;
    logic [DW-1:0] load_act, cmpa_act, cmpb_act, action_act;
    logic          sync_pending;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] m_act [4];
    logic [DW-1:0] m_sh  [4];
    logic          m_dirty [4];
    logic [7:0]    m_mode;
    logic          m_pend;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_shadow_ctrl #(.DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .sync_req(sync_req), .cnt_zero(cnt_zero), .load_act(load_act),
        .cmpa_act(cmpa_act), .cmpb_act(cmpb_act), .action_act(action_act),
        .sync_pending(sync_pending)
    );

    function automatic logic [DW-1:0] dut_act(input int i);
        case (i)
            0:       return load_act;
            1:       return cmpa_act;
            2:       return cmpb_act;
            default: return action_act;
        endcase
    endfunction

    function automatic bit is_imm(input int i, input logic [7:0] md);
        return (i == 3) && !md[7];
    endfunction

    function automatic bit is_glob(input int i, input logic [7:0] md);
        if (i == 3) return md[7:6] == 2'b11;
        return md[3+i];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            m_act[i] = '0; m_sh[i] = '0; m_dirty[i] = 1'b0;
        end
        m_mode = '0;
        m_pend = 1'b0;
    endtask

    task automatic model_edge();
        for (int i = 0; i < 4; i++) begin
            if (wr_en && wr_sel == 3'(i)) begin
                m_sh[i] = wr_data;
                if (is_imm(i, m_mode)) begin
                    m_act[i] = wr_data; m_dirty[i] = 1'b0;
                end else begin
                    m_dirty[i] = 1'b1;
                end
            end else if (cnt_zero && m_dirty[i] && (!is_glob(i, m_mode) || m_pend)) begin
                m_act[i] = m_sh[i];
                m_dirty[i] = 1'b0;
            end
        end
        if (wr_en && wr_sel == 3'd4) m_mode = wr_data[7:0];
        m_pend = sync_req | (m_pend & ~cnt_zero);
    endtask

    task automatic step(input logic we, input logic [2:0] sel, input logic [DW-1:0] d,
                        input logic sy, input logic z);
        @(negedge clk);
        wr_en = we; wr_sel = sel; wr_data = d; sync_req = sy; cnt_zero = z;
        @(posedge clk);
        model_edge();
        #1;
    endtask

    task automatic idle();
        step(1'b0, 3'd0, '0, 1'b0, 1'b0);
    endtask

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_model(input string req);
        for (int i = 0; i < 4; i++) chk(req, dut_act(i), m_act[i]);
        chk(req, DW'(sync_pending), DW'(m_pend));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk("R1 load", load_act, '0);
        chk("R1 cmpa", cmpa_act, '0);
        chk("R1 cmpb", cmpb_act, '0);
        chk("R1 action", action_act, '0);
        chk("R1 pend", DW'(sync_pending), '0);

        // R1/R5: default mode, load waits for zero
        step(1'b1, 3'd0, 16'h1234, 1'b0, 1'b0);
        chk("R5 load before zero", load_act, 16'h0000);
        idle();
        chk("R5 load still waiting", load_act, 16'h0000);
        step(1'b0, 3'd0, '0, 1'b0, 1'b1);
        chk("R5 load at zero", load_act, 16'h1234);

        // R3: default action policy immediate
        step(1'b1, 3'd3, 16'hAAAA, 1'b0, 1'b0);
        chk("R3 action imm", action_act, 16'hAAAA);

        // R4: policy 1 also immediate
        step(1'b1, 3'd4, 16'h0040, 1'b0, 1'b0);
        step(1'b1, 3'd3, 16'h5555, 1'b0, 1'b0);
        chk("R4 action pol1", action_act, 16'h5555);

        // R6/R7: all global
        step(1'b1, 3'd4, 16'h00F8, 1'b0, 1'b0);
        step(1'b1, 3'd1, 16'h0011, 1'b0, 1'b0);
        step(1'b0, 3'd0, '0, 1'b0, 1'b1);
        chk("R6 no pending zero", cmpa_act, 16'h0000);
        step(1'b0, 3'd0, '0, 1'b1, 1'b0);
        chk("R7 pend set", DW'(sync_pending), 16'd1);
        idle();
        chk("R7 pend held", DW'(sync_pending), 16'd1);
        chk("R6 waits for zero", cmpa_act, 16'h0000);
        step(1'b0, 3'd0, '0, 1'b0, 1'b1);
        chk("R6 applied", cmpa_act, 16'h0011);
        chk("R7 pend cleared", DW'(sync_pending), 16'd0);

        // R7: request with zero stays pending
        step(1'b1, 3'd3, 16'h0077, 1'b0, 1'b0);
        step(1'b0, 3'd0, '0, 1'b1, 1'b1);
        chk("R7 req at zero pending", DW'(sync_pending), 16'd1);
        chk("R6 action not yet", action_act, 16'h5555);
        step(1'b0, 3'd0, '0, 1'b0, 1'b1);
        chk("R6 action applied", action_act, 16'h0077);

        // R8: write with zero waits
        step(1'b1, 3'd4, 16'h0080, 1'b0, 1'b0);
        step(1'b1, 3'd2, 16'h0007, 1'b0, 1'b1);
        chk("R8 same cycle", cmpb_act, 16'h0000);
        step(1'b0, 3'd0, '0, 1'b0, 1'b1);
        chk("R8 next zero", cmpb_act, 16'h0007);

        // R9: last write wins, no repeat transfer
        step(1'b1, 3'd2, 16'h0001, 1'b0, 1'b0);
        step(1'b1, 3'd2, 16'h0002, 1'b0, 1'b0);
        step(1'b0, 3'd0, '0, 1'b0, 1'b1);
        chk("R9 last wins", cmpb_act, 16'h0002);
        step(1'b0, 3'd0, '0, 1'b0, 1'b1);
        chk("R9 clean hold", cmpb_act, 16'h0002);

        // R2: policy 2 on action is next-zero; bit4 only makes cmpa global
        step(1'b1, 3'd3, 16'h0099, 1'b0, 1'b0);
        chk("R2 action pol2 waits", action_act, 16'h0077);
        step(1'b0, 3'd0, '0, 1'b0, 1'b1);
        chk("R2 action pol2 zero", action_act, 16'h0099);
        step(1'b1, 3'd4, 16'h0017, 1'b0, 1'b0);
        step(1'b1, 3'd1, 16'h0A0A, 1'b0, 1'b0);
        step(1'b1, 3'd2, 16'h0B0B, 1'b0, 1'b0);
        step(1'b1, 3'd0, 16'h0C0C, 1'b0, 1'b0);
        step(1'b0, 3'd0, '0, 1'b0, 1'b1);
        chk("R2 bit5 local", cmpb_act, 16'h0B0B);
        chk("R2 bit4 global", cmpa_act, 16'h0011);
        chk("R2 bit3 local", load_act, 16'h0C0C);

        // R10: unused select codes
        step(1'b1, 3'd5, 16'hFFFF, 1'b0, 1'b0);
        step(1'b1, 3'd7, 16'hFFFF, 1'b0, 1'b1);
        chk_model("R10 unused selects");
        chk("R10 cmpb kept", cmpb_act, 16'h0B0B);

        // Random phase against the model
        for (int n = 0; n < 3000; n++) begin
            logic [2:0] s;
            logic [DW-1:0] d;
            s = 3'($urandom_range(0, 7));
            d = 16'($urandom);
            if (s == 3'd4 && $urandom_range(0, 1) == 0) d[7:6] = 2'b11;
            step($urandom_range(0, 2) != 0, s, d,
                 $urandom_range(0, 6) == 0, $urandom_range(0, 3) == 0);
            chk_model("R5 R6 R7 R8 R9 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule